// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block sends bytes on a single serial line and lets software steer it with 5-bit command codes. Data bytes come in through a valid/ready handshake. A baud tick input paces the line. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts 16 ticks.

Two kinds of character can go out besides data. A host command queues an Xon or Xoff flow-control character. The paired receiver can also ask for one with a single-cycle request pulse. A queued flow-control character always goes out before further data, even while the host has paused the data stream. It can be withdrawn until the cycle in which it is copied into the shift register. Other commands reset the transmitter, hold the line in a break, pause data and resume it. Every other code is accepted and ignored.

Top module: `uart_flowctl_tx`

## Requirements
- R1: After reset `txd` is 1, `in_ready` is 1 and `status` is 3'b100.
- R2: A loaded character goes out as one low start bit, then the eight data bits with bit 0 first, then one high stop bit. Each bit lasts 16 `baud_tick` pulses. The start bit appears in the cycle after the load, and the line is free one cycle after the stop bit ends.
- R3: A byte is taken in a cycle where both `in_valid` and `in_ready` are 1. `in_ready` is 1 only when all of these hold: the shifter is empty, no break is active, no flow-control character is pending, and the data stream is not paused.
- R4: Code 5'h10 or a pulse on `rx_req_xon` queues the `xon_char` value. Code 5'h11 or a pulse on `rx_req_xoff` queues the `xoff_char` value. There is one queue slot and the latest request wins. Within one cycle the order, lowest priority first, is: the slot clearing because it loads, the command, `rx_req_xon`, then `rx_req_xoff`. A pending character is loaded at the next free cycle, ahead of any data.
- R5: Code 5'h17 pauses the data stream. A character already in the shifter finishes in full, including its stop bit, and no data byte is loaded after it. Code 5'h16 resumes the data stream.
- R6: While the data stream is paused, a queued flow-control character is still loaded and sent.
- R7: Code 5'h18 empties the queue slot if its character has not been loaded. If the slot is empty, or the character is already in the shifter, the code changes nothing and the character is sent in full.
- R8: Code 5'h03 empties the shifter and returns `txd` to 1 in the next cycle. It also clears the pause, the pending character and the break. It overrides every other input in the same cycle, and a byte handed over in that cycle is dropped.
- R9: Code 5'h06 holds `txd` at 0 from the end of the current character until code 5'h07 arrives. `in_ready` stays 0 for that whole time.
- R10: Code 5'h00 and every code not named in R4 to R9 have no effect on the line, the handshake or the status.
- R11: `status[0]` is the paused state, `status[1]` is 1 while a flow-control character is pending, and `status[2]` is 1 while the shifter is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| in_valid | input | 1 | A data byte is offered |
| in_data | input | 8 | Offered data byte |
| in_ready | output | 1 | The byte on `in_data` is taken this cycle |
| cmd_stb | input | 1 | A command code is presented this cycle |
| cmd_code | input | 5 | Command code |
| rx_req_xon | input | 1 | Receiver asks for an Xon character |
| rx_req_xoff | input | 1 | Receiver asks for an Xoff character |
| xon_char | input | 8 | Value sent as Xon (normally 8'h11) |
| xoff_char | input | 8 | Value sent as Xoff (normally 8'h13) |
| txd | output | 1 | Serial line, idle high |
| status | output | 3 | {shifter empty, flow-control pending, paused} |

## Verification
The data patterns 8'hA5, 8'h3C, 8'h00 and 8'hFF show whether bit order and the start and stop polarity are right. A flow-control request made in the middle of a data frame, while a second byte is waiting, shows whether the character takes priority at the next boundary. The same request made while paused shows whether flow-control characters get past the pause. Cancel is tried three ways: before the load, with nothing pending, and after the load. These separate a withdrawn character from one that has already started. Reset and break are applied in the middle of a frame, with pause and a pending character also set, and reserved codes are issued during live traffic.

// File: rtl/uart_flowctl_tx.sv
module uart_flowctl_tx #(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  input  logic                 cmd_stb,
  input  logic [4:0]           cmd_code,
  input  logic                 rx_req_xon,
  input  logic                 rx_req_xoff,
  input  logic [DATA_BITS-1:0] xon_char,
  input  logic [DATA_BITS-1:0] xoff_char,
  output logic                 txd,
  output logic [2:0]           status
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  localparam logic [4:0] C_RESET  = 5'h03;
  localparam logic [4:0] C_BRK_ON = 5'h06;
  localparam logic [4:0] C_BRK_NO = 5'h07;
  localparam logic [4:0] C_XON    = 5'h10;
  localparam logic [4:0] C_XOFF   = 5'h11;
  localparam logic [4:0] C_RESUME = 5'h16;
  localparam logic [4:0] C_PAUSE  = 5'h17;
  localparam logic [4:0] C_CANCEL = 5'h18;

  logic                  busy, paused, brk, pend, pend_xoff;
  logic [FRAME_BITS-1:0] frame;
  logic [TW-1:0]         tcnt;
  logic [BW-1:0]         bidx;

  logic do_rst, do_pause, do_resume, do_brk_on, do_brk_off;
  logic do_xon, do_xoff, do_cancel;
  assign do_rst     = cmd_stb && cmd_code == C_RESET;
  assign do_pause   = cmd_stb && cmd_code == C_PAUSE;
  assign do_resume  = cmd_stb && cmd_code == C_RESUME;
  assign do_brk_on  = cmd_stb && cmd_code == C_BRK_ON;
  assign do_brk_off = cmd_stb && cmd_code == C_BRK_NO;
  assign do_xon     = cmd_stb && cmd_code == C_XON;
  assign do_xoff    = cmd_stb && cmd_code == C_XOFF;
  assign do_cancel  = cmd_stb && cmd_code == C_CANCEL;

  logic can_load, load_fc, load_data, bit_end;
  logic [DATA_BITS-1:0] load_byte;
  assign can_load  = !busy && !brk;
  assign load_fc   = can_load && pend;
  assign in_ready  = can_load && !pend && !paused;
  assign load_data = in_ready && in_valid;
  assign load_byte = load_fc ? (pend_xoff ? xoff_char : xon_char) : in_data;
  assign bit_end   = busy && baud_tick && tcnt == TICK_LAST;

  assign txd    = busy ? frame[bidx] : !brk;
  assign status = {!busy, pend, paused};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; paused <= 1'b0; brk <= 1'b0; pend <= 1'b0; pend_xoff <= 1'b0;
      frame <= '1; tcnt <= '0; bidx <= '0;
    end else if (do_rst) begin
      busy <= 1'b0; paused <= 1'b0; brk <= 1'b0; pend <= 1'b0; pend_xoff <= 1'b0;
      tcnt <= '0; bidx <= '0;
    end else begin
      if (load_fc || load_data) begin
        busy  <= 1'b1;
        frame <= {1'b1, load_byte, 1'b0};
        tcnt  <= '0;
        bidx  <= '0;
      end else if (busy && baud_tick) begin
        if (tcnt == TICK_LAST) begin
          tcnt <= '0;
          if (bidx == BIT_LAST) busy <= 1'b0;
          else                  bidx <= bidx + 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end

      if (do_pause)       paused <= 1'b1;
      else if (do_resume) paused <= 1'b0;

      if (do_brk_on)       brk <= 1'b1;
      else if (do_brk_off) brk <= 1'b0;

      if (rx_req_xoff)              begin pend <= 1'b1; pend_xoff <= 1'b1; end
      else if (rx_req_xon)          begin pend <= 1'b1; pend_xoff <= 1'b0; end
      else if (do_xoff)             begin pend <= 1'b1; pend_xoff <= 1'b1; end
      else if (do_xon)              begin pend <= 1'b1; pend_xoff <= 1'b0; end
      else if (do_cancel || load_fc) pend <= 1'b0;
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fc || load_data) && !do_rst |=> !txd); // R2

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !do_rst |=> !status[2]); // R3

  AST_FC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !busy && !brk && !do_rst |=> !status[2] && !in_ready); // R4

  AST_PAUSE_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && do_pause && !(bit_end && bidx == BIT_LAST) |=> busy); // R5

  AST_CANCEL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    do_cancel && !rx_req_xon && !rx_req_xoff |=> !status[1]); // R7

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> txd && status == 3'b100); // R8

  AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    do_brk_on |=> !in_ready && (!status[2] || !txd)); // R9
endmodule

// File: tb/uart_flowctl_tx_tb_top.sv
module uart_flowctl_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic cmd_stb = 1'b0;
  logic [4:0] cmd_code = 5'h00;
  logic rx_req_xon = 1'b0, rx_req_xoff = 1'b0;
  logic [7:0] xon_char = 8'h11, xoff_char = 8'h13;
  logic txd;
  logic [2:0] status;

  uart_flowctl_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .rx_req_xon(rx_req_xon), .rx_req_xoff(rx_req_xoff),
    .xon_char(xon_char), .xoff_char(xoff_char),
    .txd(txd), .status(status)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string req = "R1";
  bit comparing = 1'b0;
  bit done = 1'b0;

  int tick_div = 0;
  always @(posedge clk) begin
    #2;
    tick_div = (tick_div + 1) % 4;
    baud_tick = (tick_div == 0);
  end

  logic [7:0] feed[$];
  logic rdy_s = 1'b0;
  always @(negedge clk) rdy_s = in_ready;
  always @(posedge clk) begin
    bit acc;
    acc = in_valid && rdy_s;
    #2;
    if (acc && feed.size() > 0) void'(feed.pop_front());
    in_valid = feed.size() > 0;
    if (in_valid) in_data = feed[0];
  end

  int m_busy = 0, m_pend = 0, m_paused = 0, m_brk = 0, m_tk = 0;
  bit m_q[$];

  always @(posedge clk) begin
    bit lfc, ldat;
    logic [7:0] b;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_paused = 0; m_brk = 0; m_tk = 0; m_q.delete();
    end else if (cmd_stb && cmd_code == 5'h03) begin
      m_busy = 0; m_pend = 0; m_paused = 0; m_brk = 0; m_tk = 0; m_q.delete();
    end else begin
      lfc  = !m_busy && !m_brk && m_pend != 0;
      ldat = !m_busy && !m_brk && m_pend == 0 && !m_paused && in_valid;
      if (lfc || ldat) begin
        b = lfc ? (m_pend == 2 ? xoff_char : xon_char) : in_data;
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(b[i]);
        m_q.push_back(1'b1);
        m_busy = 1; m_tk = 0;
      end else if (m_busy && baud_tick) begin
        m_tk++;
        if (m_tk == 16) begin
          m_tk = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_busy = 0;
        end
      end
      if (lfc) m_pend = 0;
      if (cmd_stb) begin
        case (cmd_code)
          5'h10: m_pend = 1;
          5'h11: m_pend = 2;
          5'h18: m_pend = 0;
          5'h16: m_paused = 0;
          5'h17: m_paused = 1;
          5'h06: m_brk = 1;
          5'h07: m_brk = 0;
          default: ;
        endcase
      end
      if (rx_req_xon)  m_pend = 1;
      if (rx_req_xoff) m_pend = 2;
    end
  end

  function automatic logic exp_txd();
    return m_busy ? m_q[0] : !m_brk;
  endfunction
  function automatic logic exp_rdy();
    return !m_busy && !m_brk && m_pend == 0 && !m_paused;
  endfunction
  function automatic logic [2:0] exp_status();
    return {m_busy == 0, m_pend != 0, m_paused != 0};
  endfunction

  always @(negedge clk) begin
    if (comparing && !done) begin
      vectors++;
      if (txd !== exp_txd()) begin
        fails++; $display("FAIL %s txd actual=%b expected=%b t=%0t", req, txd, exp_txd(), $time);
      end
      if (in_ready !== exp_rdy()) begin
        fails++; $display("FAIL %s in_ready actual=%b expected=%b t=%0t", req, in_ready, exp_rdy(), $time);
      end
      if (status !== exp_status()) begin
        fails++; $display("FAIL R11 (%s) status actual=%b expected=%b t=%0t", req, status, exp_status(), $time);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cmd(input logic [4:0] c);
    step(1);
    cmd_stb = 1'b1; cmd_code = c;
    step(1);
    cmd_stb = 1'b0; cmd_code = 5'h00;
  endtask

  task automatic pulse_xon();
    step(1); rx_req_xon = 1'b1; step(1); rx_req_xon = 1'b0;
  endtask
  task automatic pulse_xoff();
    step(1); rx_req_xoff = 1'b1; step(1); rx_req_xoff = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(feed.size() == 0 && !in_valid && status[2] && exp_status() == 3'b100));
    step(5);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(1);
    comparing = 1'b1;
    @(negedge clk);
    check("R1 txd", {7'd0, txd}, 8'h01);
    check("R1 in_ready", {7'd0, in_ready}, 8'h01);
    check("R1 status", {5'd0, status}, 8'h04);

    req = "R2";
    feed.push_back(8'hA5); feed.push_back(8'h3C);
    feed.push_back(8'h00); feed.push_back(8'hFF);
    step(2);
    wait_idle();

    req = "R4";
    feed.push_back(8'h55); feed.push_back(8'h66);
    step(100);
    cmd(5'h10);
    wait_idle();
    pulse_xoff();
    feed.push_back(8'h77);
    wait_idle();
    feed.push_back(8'h12);
    step(50);
    cmd(5'h10);
    cmd(5'h11);
    wait_idle();

    req = "R5";
    feed.push_back(8'h81);
    step(200);
    cmd(5'h17);
    feed.push_back(8'h82); feed.push_back(8'h83);
    step(1500);
    @(negedge clk);
    check("R5 paused holds data", {5'd0, status}, 8'h05);
    req = "R6";
    pulse_xon();
    step(800);
    @(negedge clk);
    check("R6 xon sent while paused", {5'd0, status}, 8'h05);
    req = "R5";
    cmd(5'h16);
    wait_idle();

    req = "R7";
    feed.push_back(8'h91);
    step(50);
    cmd(5'h11);
    step(50);
    cmd(5'h18);
    @(negedge clk);
    check("R7 cancel before load", {7'd0, status[1]}, 8'h00);
    wait_idle();
    cmd(5'h18);
    step(10);
    cmd(5'h11);
    step(20);
    cmd(5'h18);
    @(negedge clk);
    check("R7 cancel after load keeps frame", {7'd0, status[2]}, 8'h00);
    wait_idle();

    req = "R9";
    feed.push_back(8'hA1); feed.push_back(8'hA2);
    step(100);
    cmd(5'h06);
    step(1200);
    @(negedge clk);
    check("R9 line low in break", {7'd0, txd}, 8'h00);
    check("R9 ready low in break", {7'd0, in_ready}, 8'h00);
    cmd(5'h07);
    wait_idle();

    req = "R8";
    feed.push_back(8'hB1); feed.push_back(8'hB2);
    step(300);
    cmd(5'h17);
    cmd(5'h10);
    cmd(5'h06);
    cmd(5'h03);
    @(negedge clk);
    check("R8 line idle after reset", {7'd0, txd}, 8'h01);
    check("R8 status after reset", {5'd0, status}, 8'h04);
    wait_idle();

    req = "R10";
    feed.push_back(8'hC1); feed.push_back(8'hC2);
    step(50);
    cmd(5'h00); cmd(5'h01); cmd(5'h0F); cmd(5'h19);
    cmd(5'h1A); cmd(5'h1F); cmd(5'h05); cmd(5'h12);
    @(negedge clk);
    check("R10 reserved codes leave status", {5'd0, status}, 8'h00);
    wait_idle();
    check("R10 idle afterwards", {5'd0, status}, 8'h04);

    finish_run();
  end
endmodule